// File: doc/BRIEF.md
# Bit-Serial Signed Multiplier with Sign-Row Correction

This block multiplies two two's-complement operands of `WIDTH` bits that arrive one bit per clock on two serial wires. The first operand (x) comes most significant bit first. The second operand (y) comes least significant bit first. With this opposite ordering, one complete row of the partial product matrix can be formed in each input cycle. The whole matrix is therefore formed in `WIDTH` cycles, not `2*WIDTH`. Every bit of a row lands in a different weight column. So each column is accumulated by a small ones-counter that adds at most one per cycle, and no adder sits in the input path.

The counts are first treated as an unsigned product. Signed operation comes from a correction that subtracts the sign-row products `x[W-1]·y[j]` and `x[i]·y[W-1]`, each at weight `2^(W+i)`. The terms involving the x sign bit are collected during the first `WIDTH-1` input cycles. The terms involving the y sign bit must wait for the final input cycle, because that bit arrives last. They are formed then from an `(WIDTH-1)`-bit history of the x magnitude bits. A latching stage freezes the column counts and correction vectors. A final stage then weights, sums and corrects them into a registered `2*WIDTH`-bit signed product, announced by a one-cycle `done` pulse. A new operand pair may start in the cycle right after the last bit of the previous one.

Top module: `bw_serial_mult`

## Requirements
- R1: A synchronous active-high `rst` clears `done` to 0 and `product` to 0.
- R2: An operation begins in the cycle in which `start` is high. In that cycle and the next `WIDTH-1` cycles, `x_bit` carries x[W-1], x[W-2], ..., x[0] in turn (MSB first) and `y_bit` carries y[0], y[1], ..., y[W-1] in turn (LSB first).
- R3: `product` equals the two's-complement product of x and y as a signed `2*WIDTH`-bit value, for every operand pair.
- R4: `done` is a one-cycle pulse. If `start` is sampled at clock edge k, `done` is high from edge k+WIDTH+1 to edge k+WIDTH+2 and low in the cycle before that.
- R5: `product` changes only at the edge that raises `done`, and it holds its value between pulses.
- R6: A new `start` may be given in the cycle right after the previous operand's last bit. Both products are correct, each on its own `done` pulse.
- R7: The corner pairs give exact results: most-negative × most-negative = 2^(2W-2), (-1)×(-1) = 1, and 0 × (negative) = 0.
- R8: A `start` during an unfinished operation abandons it. No `done` is produced for the abandoned operation, and the new one completes normally.
- R9: While no operation is in progress and `start` is low, `x_bit` and `y_bit` are ignored: no `done` occurs and `product` keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Marks the first bit cycle of an operand pair |
| x_bit | input | 1 | Serial multiplicand, most significant bit first |
| y_bit | input | 1 | Serial multiplier, least significant bit first |
| done | output | 1 | One-cycle pulse: `product` has just been updated |
| product | output | 2*WIDTH | Registered signed product |

## Verification
When `start` is sampled at edge k, the last bit is taken at edge k+WIDTH-1. The column counts and correction vectors are latched one edge later. The product and `done` appear at edge k+WIDTH+1. The bench samples on falling edges. It checks that `done` is still low one half-cycle after edge k+WIDTH. It checks `done` and `product` after edge k+WIDTH+1. After edge k+WIDTH+2 it confirms that the pulse has ended and the value is held.

For back-to-back operations, the first result is checked while the second operand pair is still being shifted in: after the second pair's second bit edge. The restart and idle cases are judged by the number of observed `done` pulses and by the product left on the port.

// File: rtl/bwm_pkg.sv
package bwm_pkg;
  // width of a ones-counter that can reach n
  function automatic int cnt_bits(input int n);
    return $clog2(n + 1);
  endfunction

  // width of the row index 0..n-1
  function automatic int row_bits(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/bwm_pp_gen.sv
module bwm_pp_gen
  import bwm_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               x_bit,
  input  logic               y_bit,
  output logic               take,
  output logic               first,
  output logic [2*WIDTH-2:0] col_bits,
  output logic               fin,
  output logic [WIDTH-2:0]   corr_xs,
  output logic [WIDTH-2:0]   corr_ys
);
  localparam int RW   = row_bits(WIDTH);
  localparam int NCOL = 2 * WIDTH - 1;
  localparam int LAST = WIDTH - 1;

  logic [RW-1:0]    row_q, row_c;
  logic             active_q;
  logic [WIDTH-2:0] xh_q, yh_q;   // xh_q[k] = x[W-1-k], yh_q[k] = y[k]
  logic             last_c;
  logic             xs_c;
  logic [WIDTH-2:0] xlow_c;

  always_comb begin
    take   = start | active_q;
    first  = start;
    row_c  = start ? '0 : row_q;
    last_c = take && (row_c == RW'(LAST));
    xs_c   = start ? x_bit : xh_q[0];
  end

  // x magnitude bits x[0..W-2]; x[0] is the live bit in the last cycle
  for (genvar i = 0; i < WIDTH - 1; i++) begin : g_xlow
    if (i == 0) begin : g_live
      assign xlow_c[i] = x_bit;
    end else begin : g_hist
      assign xlow_c[i] = xh_q[WIDTH-1-i];
    end
  end

  // one partial-product bit per column per cycle
  for (genvar c = 0; c < NCOL; c++) begin : g_col
    logic bit_c;
    if (c == WIDTH - 1) begin : g_mid
      assign bit_c = take & x_bit & y_bit;
    end else if (c >= WIDTH) begin : g_left
      localparam int OFS = c - WIDTH + 1;
      always_comb begin
        if (take && (int'(row_c) >= OFS)) bit_c = xh_q[row_c - RW'(OFS)] & y_bit;
        else                              bit_c = 1'b0;
      end
    end else begin : g_right
      localparam int OFS = WIDTH - 1 - c;
      always_comb begin
        if (take && (int'(row_c) >= OFS)) bit_c = yh_q[row_c - RW'(OFS)] & x_bit;
        else                              bit_c = 1'b0;
      end
    end
    assign col_bits[c] = bit_c;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q    <= '0;
      active_q <= 1'b0;
      fin      <= 1'b0;
      xh_q     <= '0;
      yh_q     <= '0;
      corr_xs  <= '0;
      corr_ys  <= '0;
    end else begin
      fin <= last_c;
      if (take) begin
        active_q <= !last_c;
        row_q    <= last_c ? '0 : row_c + 1'b1;
        if (!last_c) begin
          xh_q[row_c]    <= x_bit;
          yh_q[row_c]    <= y_bit;
          corr_xs[row_c] <= xs_c & y_bit;
        end else begin
          corr_ys <= xlow_c & {(WIDTH-1){y_bit}};
        end
      end
    end
  end
endmodule

// File: rtl/bwm_col_cnt.sv
module bwm_col_cnt #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          en,
  input  logic          inc,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)        cnt <= '0;
    else if (clear) cnt <= {{(CW-1){1'b0}}, inc};
    else if (en)    cnt <= cnt + {{(CW-1){1'b0}}, inc};
  end
endmodule

// File: rtl/bwm_final.sv
module bwm_final
  import bwm_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic                                          clk,
  input  logic                                          rst,
  input  logic                                          fin,
  input  logic [2*WIDTH-2:0][cnt_bits(WIDTH)-1:0]       cnt,
  input  logic [WIDTH-2:0]                              corr_xs,
  input  logic [WIDTH-2:0]                              corr_ys,
  output logic                                          done,
  output logic [2*WIDTH-1:0]                            product
);
  localparam int CW   = cnt_bits(WIDTH);
  localparam int NCOL = 2 * WIDTH - 1;
  localparam int PW   = 2 * WIDTH;

  logic                      lat_v;
  logic [NCOL-1:0][CW-1:0]   lat_cnt;
  logic [WIDTH-2:0]          lat_xs, lat_ys;
  logic [PW-1:0]             acc_c, corr_c, sum_c;

  always_comb begin
    acc_c = '0;
    for (int c = 0; c < NCOL; c++)
      acc_c = acc_c + ({{(PW-CW){1'b0}}, lat_cnt[c]} << c);
    corr_c = ({{(WIDTH+1){1'b0}}, lat_xs} + {{(WIDTH+1){1'b0}}, lat_ys}) << WIDTH;
    sum_c  = acc_c - corr_c;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_v   <= 1'b0;
      lat_cnt <= '0;
      lat_xs  <= '0;
      lat_ys  <= '0;
      done    <= 1'b0;
      product <= '0;
    end else begin
      lat_v <= fin;
      if (fin) begin
        lat_cnt <= cnt;
        lat_xs  <= corr_xs;
        lat_ys  <= corr_ys;
      end
      done <= lat_v;
      if (lat_v) product <= sum_c;
    end
  end
endmodule

// File: rtl/bw_serial_mult.sv
module bw_serial_mult
  import bwm_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic                      x_bit,
  input  logic                      y_bit,
  output logic                      done,
  output logic signed [2*WIDTH-1:0] product
);
  localparam int CW   = cnt_bits(WIDTH);
  localparam int NCOL = 2 * WIDTH - 1;

  logic                    take, first, fin;
  logic [NCOL-1:0]         col_bits;
  logic [WIDTH-2:0]        corr_xs, corr_ys;
  logic [NCOL-1:0][CW-1:0] cnt;
  logic [2*WIDTH-1:0]      prod_u;

  bwm_pp_gen #(.WIDTH(WIDTH)) pp_i (
    .clk(clk), .rst(rst), .start(start), .x_bit(x_bit), .y_bit(y_bit),
    .take(take), .first(first), .col_bits(col_bits), .fin(fin),
    .corr_xs(corr_xs), .corr_ys(corr_ys)
  );

  for (genvar c = 0; c < NCOL; c++) begin : g_cnt
    bwm_col_cnt #(.CW(CW)) cnt_i (
      .clk(clk), .rst(rst), .clear(first), .en(take),
      .inc(col_bits[c]), .cnt(cnt[c])
    );
  end

  bwm_final #(.WIDTH(WIDTH)) fin_i (
    .clk(clk), .rst(rst), .fin(fin), .cnt(cnt),
    .corr_xs(corr_xs), .corr_ys(corr_ys),
    .done(done), .product(prod_u)
  );

  assign product = prod_u;
endmodule

// File: rtl/bwm_chk.sv
module bwm_chk #(
  parameter int WIDTH = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               start,
  input logic               done,
  input logic [2*WIDTH-1:0] product
);
  localparam int KW = $clog2(WIDTH + 1);

  // bits accepted in the current operand window
  logic [KW-1:0] win_q;
  always_ff @(posedge clk) begin
    if (rst)                                  win_q <= '0;
    else if (start)                           win_q <= KW'(1);
    else if (win_q != '0 && win_q != KW'(WIDTH)) win_q <= win_q + 1'b1;
    else                                      win_q <= '0;
  end

  // R1
  rst_clear_chk: assert property (@(posedge clk) $past(rst) |-> (!done && product == '0));

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);

  // R4
  window_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(win_q == KW'(WIDTH), 2));

  // R5
  prod_hold_chk: assert property (@(posedge clk) disable iff (rst) !done |-> $stable(product));
endmodule

bind bw_serial_mult bwm_chk #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .rst(rst), .start(start), .done(done), .product(product)
);

// File: tb/bw_serial_mult_tb.sv
`timescale 1ns/1ps
module bw_serial_mult_tb_top;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic x_bit = 1'b0;
  logic y_bit = 1'b0;
  logic done;
  logic signed [2*N-1:0] product;

  int n_chk = 0;
  int n_fail = 0;
  int dcount = 0;

  always #2.5 clk = ~clk;

  bw_serial_mult #(.WIDTH(N)) dut_i (
    .clk(clk), .rst(rst), .start(start), .x_bit(x_bit), .y_bit(y_bit),
    .done(done), .product(product)
  );

  always @(negedge clk) if (done === 1'b1) dcount++;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R2 framing: x MSB first, y LSB first, start with the first bit
  task automatic drive_op(input logic [N-1:0] a, input logic [N-1:0] b);
    for (int r = 0; r < N; r++) begin
      @(negedge clk);
      start = (r == 0);
      x_bit = a[N-1-r];
      y_bit = b[r];
    end
  endtask

  task automatic idle_drive();
    @(negedge clk);
    start = 1'b0;
    x_bit = 1'($urandom);
    y_bit = 1'($urandom);
  endtask

  task automatic run_check(input logic signed [N-1:0] a, input logic signed [N-1:0] b,
                           input string tag);
    longint exp;
    exp = longint'(a) * longint'(b);
    drive_op(a, b);
    idle_drive();                     // after last bit edge
    idle_drive();                     // after latch edge
    check(done == 1'b0, "R4 early", longint'(done), 0);
    idle_drive();                     // after result edge
    check(done == 1'b1, "R4 pulse", longint'(done), 1);
    check(longint'(product) == exp, tag, longint'(product), exp);
    idle_drive();
    check(done == 1'b0, "R4 end", longint'(done), 0);
    check(longint'(product) == exp, "R5 hold", longint'(product), exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    longint p0;
    int d0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(done == 1'b0, "R1 done", longint'(done), 0);
    check(product == '0, "R1 product", longint'(product), 0);

    // R2: ordering sensitive pair
    run_check(4'sd1, 4'sd2, "R2");
    run_check(4'sd4, 4'sd1, "R2");

    // R7 corners
    run_check(-4'sd8, -4'sd8, "R7");
    run_check(-4'sd1, -4'sd1, "R7");
    run_check(4'sd0, -4'sd5, "R7");

    // R3 exhaustive sweep
    for (int ai = -8; ai < 8; ai++)
      for (int bi = -8; bi < 8; bi++)
        run_check(N'(ai), N'(bi), "R3");

    // R6 back-to-back
    begin
      longint ea, eb;
      ea = -8 * 7;
      eb = 1;
      drive_op(-4'sd8, 4'sd7);
      for (int r = 0; r < N; r++) begin
        @(negedge clk);
        if (r == 2) begin
          check(done == 1'b1, "R6 first done", longint'(done), 1);
          check(longint'(product) == ea, "R6 first", longint'(product), ea);
        end
        start = (r == 0);
        x_bit = 1'b1;
        y_bit = 1'b1;
      end
      idle_drive();
      idle_drive();
      idle_drive();
      check(done == 1'b1, "R6 second done", longint'(done), 1);
      check(longint'(product) == eb, "R6 second", longint'(product), eb);
      idle_drive();
    end

    // R8 restart
    d0 = dcount;
    @(negedge clk); start = 1'b1; x_bit = 1'b0; y_bit = 1'b1;
    @(negedge clk); start = 1'b0; x_bit = 1'b1; y_bit = 1'b1;
    run_check(-4'sd3, 4'sd6, "R8");
    check(dcount == d0 + 1, "R8 pulses", dcount - d0, 1);

    // R9 idle inputs ignored
    p0 = longint'(product);
    d0 = dcount;
    repeat (20) idle_drive();
    idle_drive();
    check(dcount == d0, "R9 pulses", dcount - d0, 0);
    check(longint'(product) == p0, "R9 product", longint'(product), p0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule